// File: doc/BRIEF.md
# Pin Event Interrupt Detector

This block watches a bank of general-purpose input pins and turns selected pin events into interrupts. Each pin can trigger on a rising edge, a falling edge, a high level and a low level, and the four conditions are enabled independently, so any mix is allowed (for example rising edge together with low level). A detected condition sets a sticky pending bit. Software clears pending bits by writing ones to them. A per-pin enable mask decides which pending bits drive the single combined interrupt line.

Each pin can optionally go through a stability filter before detection. A filtered pin only takes a new value after that value has held for a fixed number of consecutive clock cycles, so short glitches are dropped. Software reaches the block through a flat 32-bit register port with combinational reads and single-cycle writes. The per-pin pending vector is also brought out directly.

Top module: `pin_evt_irq`

## Requirements
- R1: After reset, every control register (interrupt enable, the four trigger enables, filter enable), every pending bit and the interrupt line read as zero.
- R2: A read of address 0 returns the conditioned input value of each pin (filtered where its filter is enabled, raw sample otherwise). A write to address 0 has no effect.
- R3: With the rise enable of a pin set (address 3), a 0-to-1 change of its conditioned input sets its pending bit.
- R4: With the fall enable of a pin set (address 4), a 1-to-0 change of its conditioned input sets its pending bit.
- R5: With the high-level enable of a pin set (address 5), the pending bit is set on every cycle the conditioned input is 1, so clearing it does not last while the level holds.
- R6: With the low-level enable of a pin set (address 6), the pending bit is set on every cycle the conditioned input is 0.
- R7: The four trigger enables of a pin combine freely; the pending bit is set when any enabled condition occurs.
- R8: Writing to address 1 clears each pending bit whose write-data bit is 1 and leaves the other bits unchanged. Without such a write, a pending bit never falls. Reads of address 1 return the pending vector.
- R9: When a trigger condition and a clear hit the same bit in the same cycle, the bit stays set.
- R10: The interrupt line is the OR over all pins of pending AND interrupt enable (address 2), and `pend_o` always equals the pending vector.
- R11: For a pin whose filter enable (address 7) is set, a new input value reaches detection only after it has held for 16 consecutive cycles. A shorter pulse produces neither an event nor a change at address 0.
- R12: For a pin whose filter enable is clear, the raw sample feeds detection directly, so pulses of a few cycles are detected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| pins_i | input | 32 | Input pin levels |
| bus_we_i | input | 1 | Register write strobe, one write per cycle it is high |
| bus_addr_i | input | 3 | Register address: 0 input data, 1 pending, 2 interrupt enable, 3 rise, 4 fall, 5 high, 6 low, 7 filter enable |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for the register at `bus_addr_i`, combinational |
| pend_o | output | 32 | Pending vector |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench aims a clear write at the same cycle in which an edge sets a pending bit. A design that let the clear win would lose that event. It clears level-triggered bits while the level still holds and expects them back; a design that treats levels as one-shot events would leave them clear. It sends pulses shorter than the filter window into filtered and unfiltered pins at the same time. A filter that counted wrongly or ignored its enable would pass the glitch or hide a real pulse. Random trigger mixes check that the enables combine as an OR, and partial clear masks check that a write-one-to-clear touches no bit written with zero.

// File: rtl/pin_evt_pkg.sv
package pin_evt_pkg;

  localparam int unsigned REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    REG_DIN  = 3'd0,
    REG_PEND = 3'd1,
    REG_IEN  = 3'd2,
    REG_RISE = 3'd3,
    REG_FALL = 3'd4,
    REG_HIGH = 3'd5,
    REG_LOW  = 3'd6,
    REG_FILT = 3'd7
  } reg_sel_e;

  // number of plain read/write control registers, starting at REG_IEN
  localparam int unsigned NUM_CTRL = 6;

endpackage

// File: rtl/pin_evt_regs.sv
module pin_evt_regs
  import pin_evt_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32
) (
  input  logic                clk_i,
  input  logic                rst_n,
  input  logic                we_i,
  input  logic [REG_AW-1:0]   addr_i,
  input  logic [NUM_PINS-1:0] wdata_i,
  output logic [NUM_PINS-1:0] ien_o,
  output logic [NUM_PINS-1:0] rise_o,
  output logic [NUM_PINS-1:0] fall_o,
  output logic [NUM_PINS-1:0] high_o,
  output logic [NUM_PINS-1:0] low_o,
  output logic [NUM_PINS-1:0] filt_o
);

  logic [NUM_PINS-1:0] ctrl_q [NUM_CTRL];
  logic [NUM_PINS-1:0] ctrl_d [NUM_CTRL];
  logic [NUM_CTRL-1:0] ctrl_en;

  for (genvar k = 0; k < NUM_CTRL; k++) begin : g_ctrl
    localparam logic [REG_AW-1:0] ADDR_K = REG_AW'(int'(REG_IEN) + k);

    assign ctrl_en[k] = we_i && (addr_i == ADDR_K);

    always_comb begin
      ctrl_d[k] = ctrl_q[k];
      if (ctrl_en[k]) begin
        ctrl_d[k] = wdata_i;
      end
    end

    always_ff @(posedge clk_i or negedge rst_n) begin
      if (!rst_n) begin
        ctrl_q[k] <= '0;
      end else if (ctrl_en[k]) begin
        ctrl_q[k] <= ctrl_d[k];
      end
    end
  end

  assign ien_o  = ctrl_q[0];
  assign rise_o = ctrl_q[1];
  assign fall_o = ctrl_q[2];
  assign high_o = ctrl_q[3];
  assign low_o  = ctrl_q[4];
  assign filt_o = ctrl_q[5];

endmodule

// File: rtl/pin_evt_cond.sv
module pin_evt_cond #(
  parameter int unsigned NUM_PINS      = 32,
  parameter int unsigned STABLE_CYCLES = 16
) (
  input  logic                clk_i,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pins_i,
  input  logic [NUM_PINS-1:0] filt_en_i,
  output logic [NUM_PINS-1:0] samp_o,
  output logic [NUM_PINS-1:0] filt_o,
  output logic [NUM_PINS-1:0] cond_o
);

  localparam int unsigned CW = $clog2(STABLE_CYCLES + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(STABLE_CYCLES - 1);

  logic [NUM_PINS-1:0] samp_q;

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      samp_q <= '0;
    end else begin
      samp_q <= pins_i;
    end
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic [CW-1:0] cnt_q, cnt_d;
    logic          filt_q, filt_d;
    logic          differs;

    assign differs = samp_q[p] ^ filt_q;

    always_comb begin
      cnt_d  = '0;
      filt_d = filt_q;
      if (differs) begin
        if (cnt_q == CNT_LAST) begin
          filt_d = samp_q[p];
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    end

    always_ff @(posedge clk_i or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q  <= '0;
        filt_q <= 1'b0;
      end else begin
        cnt_q  <= cnt_d;
        filt_q <= filt_d;
      end
    end

    assign filt_o[p] = filt_q;
    assign cond_o[p] = filt_en_i[p] ? filt_q : samp_q[p];
  end

  assign samp_o = samp_q;

endmodule

// File: rtl/pin_evt_detect.sv
module pin_evt_detect #(
  parameter int unsigned NUM_PINS = 32
) (
  input  logic                clk_i,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] cond_i,
  input  logic [NUM_PINS-1:0] rise_en_i,
  input  logic [NUM_PINS-1:0] fall_en_i,
  input  logic [NUM_PINS-1:0] high_en_i,
  input  logic [NUM_PINS-1:0] low_en_i,
  input  logic [NUM_PINS-1:0] clr_i,
  output logic [NUM_PINS-1:0] set_o,
  output logic [NUM_PINS-1:0] pend_o
);

  logic [NUM_PINS-1:0] prev_q;
  logic [NUM_PINS-1:0] pend_q, pend_d;
  logic [NUM_PINS-1:0] went_up, went_down;

  assign went_up   =  cond_i & ~prev_q;
  assign went_down = ~cond_i &  prev_q;

  assign set_o = (rise_en_i & went_up)
               | (fall_en_i & went_down)
               | (high_en_i & cond_i)
               | (low_en_i  & ~cond_i);

  // a new event outranks a same-cycle clear
  always_comb begin
    pend_d = (pend_q & ~clr_i) | set_o;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= cond_i;
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;

endmodule

// File: rtl/pin_evt_irq.sv
module pin_evt_irq
  import pin_evt_pkg::*;
#(
  parameter int unsigned NUM_PINS      = 32,
  parameter int unsigned STABLE_CYCLES = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pins_i,
  input  logic                bus_we_i,
  input  logic [REG_AW-1:0]   bus_addr_i,
  input  logic [NUM_PINS-1:0] bus_wdata_i,
  output logic [NUM_PINS-1:0] bus_rdata_o,
  output logic [NUM_PINS-1:0] pend_o,
  output logic                irq_o
);

  logic [1:0]          rst_sync_q;
  logic                rst_n;
  logic [NUM_PINS-1:0] ien, rise_en, fall_en, high_en, low_en, filt_en;
  logic [NUM_PINS-1:0] samp, filt, cond, set_vec, pend, clr_vec;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n = rst_sync_q[1];

  pin_evt_regs #(.NUM_PINS(NUM_PINS)) regs_i (
    .clk_i   (clk_i),
    .rst_n   (rst_n),
    .we_i    (bus_we_i),
    .addr_i  (bus_addr_i),
    .wdata_i (bus_wdata_i),
    .ien_o   (ien),
    .rise_o  (rise_en),
    .fall_o  (fall_en),
    .high_o  (high_en),
    .low_o   (low_en),
    .filt_o  (filt_en)
  );

  pin_evt_cond #(.NUM_PINS(NUM_PINS), .STABLE_CYCLES(STABLE_CYCLES)) cond_i (
    .clk_i     (clk_i),
    .rst_n     (rst_n),
    .pins_i    (pins_i),
    .filt_en_i (filt_en),
    .samp_o    (samp),
    .filt_o    (filt),
    .cond_o    (cond)
  );

  assign clr_vec = (bus_we_i && bus_addr_i == REG_PEND) ? bus_wdata_i : '0;

  pin_evt_detect #(.NUM_PINS(NUM_PINS)) det_i (
    .clk_i     (clk_i),
    .rst_n     (rst_n),
    .cond_i    (cond),
    .rise_en_i (rise_en),
    .fall_en_i (fall_en),
    .high_en_i (high_en),
    .low_en_i  (low_en),
    .clr_i     (clr_vec),
    .set_o     (set_vec),
    .pend_o    (pend)
  );

  always_comb begin
    unique case (bus_addr_i)
      REG_DIN:  bus_rdata_o = cond;
      REG_PEND: bus_rdata_o = pend;
      REG_IEN:  bus_rdata_o = ien;
      REG_RISE: bus_rdata_o = rise_en;
      REG_FALL: bus_rdata_o = fall_en;
      REG_HIGH: bus_rdata_o = high_en;
      REG_LOW:  bus_rdata_o = low_en;
      REG_FILT: bus_rdata_o = filt_en;
      default:  bus_rdata_o = '0;
    endcase
  end

  assign pend_o = pend;
  assign irq_o  = |(pend & ien);

endmodule

// File: rtl/pin_evt_irq_chk.sv
module pin_evt_irq_chk
  import pin_evt_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32
) (
  input logic                clk_i,
  input logic                rst_n,
  input logic                we,
  input logic [REG_AW-1:0]   addr,
  input logic [NUM_PINS-1:0] wdata,
  input logic [NUM_PINS-1:0] pend,
  input logic [NUM_PINS-1:0] ien,
  input logic                irq,
  input logic [NUM_PINS-1:0] set_vec,
  input logic [NUM_PINS-1:0] samp,
  input logic [NUM_PINS-1:0] filt
);

  // R8: a clear removes every written-one bit that no event re-set
  a_r8_w1c_clears: assert property (@(posedge clk_i) disable iff (!rst_n)
    (we && addr == REG_PEND) |=> ((pend & $past(wdata) & ~$past(set_vec)) == '0));

  // R8: without a clear write, pending bits never fall
  a_r8_sticky: assert property (@(posedge clk_i) disable iff (!rst_n)
    !(we && addr == REG_PEND) |=> ((pend & $past(pend)) == $past(pend)));

  // R9: an event always lands, even against a clear
  a_r9_set_wins: assert property (@(posedge clk_i) disable iff (!rst_n)
    (set_vec != '0) |=> ((pend & $past(set_vec)) == $past(set_vec)));

  // R10: combined line follows enabled pending bits
  a_r10_irq_or: assert property (@(posedge clk_i) disable iff (!rst_n)
    irq == ((pend & ien) != '0));

  // R11: a filtered value only ever moves to the value that was sampled
  a_r11_filter_follows: assert property (@(posedge clk_i) disable iff (!rst_n)
    1'b1 |=> (((filt ^ $past(filt)) & ($past(samp) ^ filt)) == '0));

endmodule

bind pin_evt_irq pin_evt_irq_chk #(.NUM_PINS(NUM_PINS)) chk_i (
  .clk_i   (clk_i),
  .rst_n   (rst_n),
  .we      (bus_we_i),
  .addr    (bus_addr_i),
  .wdata   (bus_wdata_i),
  .pend    (pend),
  .ien     (ien),
  .irq     (irq_o),
  .set_vec (set_vec),
  .samp    (samp),
  .filt    (filt)
);

// File: tb/pin_evt_irq_tb_top.sv
`timescale 1ns/1ps
module pin_evt_irq_tb_top;

  localparam int N = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] pins = '0;
  logic         we = 1'b0;
  logic [2:0]   addr = 3'd0;
  logic [N-1:0] wdata = '0;
  logic [N-1:0] rdata, pend;
  logic         irq;

  int n_cmp = 0;
  int n_bad = 0;

  logic [N-1:0] c_ien, c_rise, c_fall, c_high, c_low;

  always #4 clk = ~clk;

  pin_evt_irq #(.NUM_PINS(N), .STABLE_CYCLES(16)) dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .pins_i      (pins),
    .bus_we_i    (we),
    .bus_addr_i  (addr),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .pend_o      (pend),
    .irq_o       (irq)
  );

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0; addr = 3'd0; wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [N-1:0] d);
    addr = a;
    #1;
    d = rdata;
    addr = 3'd0;
  endtask

  task automatic cfg(input logic [N-1:0] ie, r, f, h, l, fe);
    c_ien = ie; c_rise = r; c_fall = f; c_high = h; c_low = l;
    wr(3'd2, ie); wr(3'd3, r); wr(3'd4, f); wr(3'd5, h); wr(3'd6, l); wr(3'd7, fe);
  endtask

  function automatic logic [N-1:0] lvl_set(input logic [N-1:0] v);
    return (c_high & v) | (c_low & ~v);
  endfunction

  function automatic logic [N-1:0] move_set(input logic [N-1:0] o, input logic [N-1:0] n);
    return (c_rise & ~o & n) | (c_fall & o & ~n) | lvl_set(o) | lvl_set(n);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [N-1:0] v, o, nw, ex;
    int seed;
    seed = $urandom(32'h5EED_0042);

    idle(3);
    rst_n = 1'b1;
    idle(5);

    // R1: reset state
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      chk("R1 reg read", v, '0);
    end
    chk("R1 pend", pend, '0);
    chk("R1 irq", {31'b0, irq}, '0);

    // R2: address 0 follows the pins, writes to it ignored
    cfg('0, '0, '0, '0, '0, '0);
    pins = 32'hA5C3_0F11;
    idle(3);
    rd(3'd0, v);
    chk("R2 din", v, 32'hA5C3_0F11);
    wr(3'd0, 32'h1234_5678);
    rd(3'd0, v);
    chk("R2 din write ignored", v, 32'hA5C3_0F11);
    chk("R2 no pend", pend, '0);

    // R3 + R8: rising on all pins, then partial clear
    pins = '0;
    idle(4);
    cfg('0, '1, '0, '0, '0, '0);
    pins = '1;
    idle(3);
    chk("R3 rise all", pend, '1);
    wr(3'd1, 32'h0000_FFFF);
    chk("R8 partial clear", pend, 32'hFFFF_0000);
    rd(3'd1, v);
    chk("R8 pend readback", v, 32'hFFFF_0000);

    // R4: falling only
    wr(3'd1, '1);
    cfg('0, '0, '1, '0, '0, '0);
    pins = 32'h0F0F_0000;
    idle(3);
    chk("R4 fall", pend, 32'hF0F0_FFFF);

    // R5/R6: levels re-set after clear
    cfg('0, '0, '0, 32'h0000_00FF, 32'h0000_FF00, '0);
    pins = 32'h0000_00F0;
    idle(2);
    wr(3'd1, '1);
    idle(1);
    chk("R5 R6 level persists over clear", pend & 32'h0000_FFFF, 32'h0000_FFF0);

    // R9: edge set and clear in the same cycle
    cfg('0, '1, '0, '0, '0, '0);
    pins = '0;
    idle(4);
    wr(3'd1, '1);
    @(negedge clk);
    pins = 32'h0000_0020;
    wr(3'd1, '1);
    chk("R9 set beats clear", pend, 32'h0000_0020);

    // R10: interrupt gating
    wr(3'd2, '0);
    chk("R10 irq masked", {31'b0, irq}, '0);
    wr(3'd2, 32'h0000_0020);
    chk("R10 irq on", {31'b0, irq}, 32'd1);
    wr(3'd2, ~32'h0000_0020);
    chk("R10 irq other pins", {31'b0, irq}, '0);

    // R11: filter on all pins
    cfg('0, '1, '0, '0, '0, '1);
    pins = '0;
    idle(20);
    wr(3'd1, '1);
    pins = '1;
    idle(10);
    pins = '0;
    idle(25);
    chk("R11 short pulse dropped", pend, '0);
    rd(3'd0, v);
    chk("R11 din unchanged", v, '0);
    pins = '1;
    idle(8);
    rd(3'd0, v);
    chk("R11 din still old mid-window", v, '0);
    idle(20);
    rd(3'd0, v);
    chk("R11 din after window", v, '1);
    chk("R11 event after window", pend, '1);

    // R12: filter only on low half
    cfg('0, '1, '0, '0, '0, 32'h0000_FFFF);
    pins = '0;
    idle(25);
    wr(3'd1, '1);
    pins = '1;
    idle(3);
    pins = '0;
    idle(25);
    chk("R12 bypass pins see pulse", pend, 32'hFFFF_0000);

    // R7: random trigger mixes, unfiltered
    for (int t = 0; t < 24; t++) begin
      cfg($urandom(), $urandom(), $urandom(), $urandom(), $urandom(), '0);
      o = $urandom();
      pins = o;
      idle(4);
      wr(3'd1, '1);
      idle(2);
      chk("R7 R8 after clear", pend, lvl_set(o));
      nw = $urandom();
      pins = nw;
      idle(4);
      ex = move_set(o, nw);
      chk("R7 mixed triggers", pend, ex);
      chk("R10 irq random", {31'b0, irq}, {31'b0, |(ex & c_ien)});
      rd(3'd0, v);
      chk("R2 din random", v, nw);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule